// File: doc/BRIEF.md
# Write-Once Synchronizing Memory Server

This block sits at a memory node and serves a stream of split-phase memory requests against a local array of tagged words. Each word holds a data field, a type tag and a presence state. Plain fetches and plain stores read and write the word directly. Write-once fetches and stores use the presence state to synchronize a reader with a writer. A write-once fetch that finds its word empty parks its return continuation inside the word. The matching write-once store then writes the value and turns the parked continuation into a reply.

A reply is a token made of a continuation and a tagged value. Downstream logic uses it to start a new thread. Stores produce no acknowledgment. Both the request and the reply channels are valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A reply is consumed on an edge where `rsp_valid` and `rsp_ready` are both high. While a reply waits, `req_ready` stays low, so nothing behind the reply can overtake it. Requests are served one at a time in arrival order. Two error outputs pulse for one cycle when the write-once protocol is broken.

Top module: `istr_mem_server`

## Requirements
- R1: After reset, every word is empty with zero data and zero type, `rsp_valid` and both error outputs are low, and `req_ready` is high.
- R2: A plain fetch (opcode 0) gives a reply on the first edge after acceptance, whatever the presence state. The reply carries the word's data and type, and its continuation is bits [CONT_W-1:0] of `req_payload`.
- R3: A plain store (opcode 1) writes `req_payload` and `req_type` into the word and marks it full. It gives no reply, unless the word held a parked reader. In that case the reader receives a reply carrying its parked continuation and the new value.
- R4: Requests are served in arrival order, so a fetch accepted after a store to the same word returns the stored value.
- R5: A write-once fetch (opcode 2) to an empty word records the continuation in the word, marks it deferred and gives no reply.
- R6: A write-once store (opcode 3) to a deferred word writes the value, marks the word full and replies with the parked continuation, the new data and the new type.
- R7: A write-once fetch to a full word replies at once with the stored data and type.
- R8: A write-once store to a full word pulses `err_dup_store` on the first edge after acceptance. The stored data is left unchanged and no reply is given.
- R9: A write-once fetch to a deferred word pulses `err_dup_fetch` on the first edge after acceptance. It gives no reply and keeps the original parked reader.
- R10: A reply holds `rsp_valid` and its contents steady until `rsp_ready` is high. `req_ready` is low whenever `rsp_valid` is high.
- R11: A write-once store to an empty word writes the value and marks the word full. It gives no reply and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (no reply pending) |
| req_op | input | 2 | 0 fetch, 1 store, 2 write-once fetch, 3 write-once store |
| req_offset | input | ADDR_W | Word offset |
| req_payload | input | DATA_W | Store value, or return continuation in the low CONT_W bits |
| req_type | input | TYPE_W | Type tag for stores |
| rsp_valid | output | 1 | Reply token present |
| rsp_ready | input | 1 | Reply consumer ready |
| rsp_cont | output | CONT_W | Continuation of the new thread |
| rsp_data | output | DATA_W | Value carried by the reply |
| rsp_type | output | TYPE_W | Type tag carried by the reply |
| err_dup_store | output | 1 | One-cycle pulse: write-once store to a full word |
| err_dup_fetch | output | 1 | One-cycle pulse: second reader on a deferred word |

## Verification
A wrong presence state does not show at the ports right away. It shows on the next request to the same word. A word wrongly left empty gives no reply and never raises an error. A word wrongly marked full raises a spurious `err_dup_store`, or returns data at once when the reader should have waited. A corrupted parked continuation shows in `rsp_cont` of the reply released by the store, one edge after that store is accepted. The bench therefore returns to each word after the access that changed it, and compares every reply token against a queue of expected tokens.

// File: rtl/istr_pkg.sv
package istr_pkg;
  typedef enum logic [1:0] {
    OP_FETCH  = 2'd0,
    OP_STORE  = 2'd1,
    OP_IFETCH = 2'd2,
    OP_ISTORE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PS_EMPTY = 2'd0,
    PS_DEFER = 2'd1,
    PS_FULL  = 2'd2
  } pres_e;
endpackage

// File: rtl/istr_cell_array.sv
module istr_cell_array
  import istr_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64,
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [TYPE_W-1:0] rd_type,
  output pres_e             rd_state,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TYPE_W-1:0] wr_type,
  input  pres_e             wr_state
);
  logic [DATA_W-1:0] data_q  [DEPTH];
  logic [TYPE_W-1:0] type_q  [DEPTH];
  pres_e             state_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q[i]  <= '0;
        type_q[i]  <= '0;
        state_q[i] <= PS_EMPTY;
      end else if (wr_en && wr_addr == ADDR_W'(i)) begin
        data_q[i]  <= wr_data;
        type_q[i]  <= wr_type;
        state_q[i] <= wr_state;
      end
    end
  end

  always_comb begin
    rd_data  = data_q[rd_addr];
    rd_type  = type_q[rd_addr];
    rd_state = state_q[rd_addr];
  end
endmodule

// File: rtl/istr_ctrl.sv
module istr_ctrl
  import istr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TYPE_W = 8,
  parameter int CONT_W = 32
) (
  input  logic              fire,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] payload,
  input  logic [TYPE_W-1:0] ptype,
  input  logic [DATA_W-1:0] cur_data,
  input  logic [TYPE_W-1:0] cur_type,
  input  pres_e             cur_state,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [TYPE_W-1:0] wr_type,
  output pres_e             wr_state,
  output logic              rep_load,
  output logic [CONT_W-1:0] rep_cont,
  output logic [DATA_W-1:0] rep_data,
  output logic [TYPE_W-1:0] rep_type,
  output logic              dup_store,
  output logic              dup_fetch
);
  logic [CONT_W-1:0] req_cont;
  logic [CONT_W-1:0] parked_cont;

  assign req_cont    = payload[CONT_W-1:0];
  assign parked_cont = cur_data[CONT_W-1:0];

  always_comb begin
    wr_en     = 1'b0;
    wr_data   = payload;
    wr_type   = ptype;
    wr_state  = PS_FULL;
    rep_load  = 1'b0;
    rep_cont  = req_cont;
    rep_data  = cur_data;
    rep_type  = cur_type;
    dup_store = 1'b0;
    dup_fetch = 1'b0;
    if (fire) begin
      unique case (op_e'(op))
        OP_FETCH: rep_load = 1'b1;
        OP_STORE, OP_ISTORE: begin
          if (op_e'(op) == OP_ISTORE && cur_state == PS_FULL) begin
            dup_store = 1'b1;
          end else begin
            wr_en = 1'b1;
            if (cur_state == PS_DEFER) begin
              rep_load = 1'b1;
              rep_cont = parked_cont;
              rep_data = payload;
              rep_type = ptype;
            end
          end
        end
        OP_IFETCH: begin
          unique case (cur_state)
            PS_EMPTY: begin
              wr_en    = 1'b1;
              wr_data  = DATA_W'(req_cont);
              wr_type  = cur_type;
              wr_state = PS_DEFER;
            end
            PS_DEFER: dup_fetch = 1'b1;
            default:  rep_load  = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/istr_reply_reg.sv
module istr_reply_reg #(
  parameter int DATA_W = 64,
  parameter int TYPE_W = 8,
  parameter int CONT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CONT_W-1:0] in_cont,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TYPE_W-1:0] in_type,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CONT_W-1:0] out_cont,
  output logic [DATA_W-1:0] out_data,
  output logic [TYPE_W-1:0] out_type
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cont  <= '0;
      out_data  <= '0;
      out_type  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_cont  <= in_cont;
      out_data  <= in_data;
      out_type  <= in_type;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/istr_mem_server.sv
module istr_mem_server
  import istr_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 64,
  parameter int TYPE_W = 8,
  parameter int CONT_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [DATA_W-1:0] req_payload,
  input  logic [TYPE_W-1:0] req_type,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CONT_W-1:0] rsp_cont,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TYPE_W-1:0] rsp_type,
  output logic              err_dup_store,
  output logic              err_dup_fetch
);
  logic              fire;
  logic [DATA_W-1:0] cur_data;
  logic [TYPE_W-1:0] cur_type;
  pres_e             cur_state;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [TYPE_W-1:0] wr_type;
  pres_e             wr_state;
  logic              rep_load;
  logic [CONT_W-1:0] rep_cont;
  logic [DATA_W-1:0] rep_data;
  logic [TYPE_W-1:0] rep_type;
  logic              dup_store;
  logic              dup_fetch;

  assign req_ready = !rsp_valid;
  assign fire      = req_valid && req_ready;

  istr_cell_array #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TYPE_W(TYPE_W)
  ) u_cells (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(req_offset), .rd_data(cur_data), .rd_type(cur_type),
    .rd_state(cur_state),
    .wr_en(wr_en), .wr_addr(req_offset), .wr_data(wr_data),
    .wr_type(wr_type), .wr_state(wr_state)
  );

  istr_ctrl #(
    .DATA_W(DATA_W), .TYPE_W(TYPE_W), .CONT_W(CONT_W)
  ) u_ctrl (
    .fire(fire), .op(req_op), .payload(req_payload), .ptype(req_type),
    .cur_data(cur_data), .cur_type(cur_type), .cur_state(cur_state),
    .wr_en(wr_en), .wr_data(wr_data), .wr_type(wr_type), .wr_state(wr_state),
    .rep_load(rep_load), .rep_cont(rep_cont), .rep_data(rep_data),
    .rep_type(rep_type), .dup_store(dup_store), .dup_fetch(dup_fetch)
  );

  istr_reply_reg #(
    .DATA_W(DATA_W), .TYPE_W(TYPE_W), .CONT_W(CONT_W)
  ) u_reply (
    .clk(clk), .rst_n(rst_n), .load(rep_load),
    .in_cont(rep_cont), .in_data(rep_data), .in_type(rep_type),
    .out_ready(rsp_ready), .out_valid(rsp_valid),
    .out_cont(rsp_cont), .out_data(rsp_data), .out_type(rsp_type)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_dup_store <= 1'b0;
      err_dup_fetch <= 1'b0;
    end else begin
      err_dup_store <= dup_store;
      err_dup_fetch <= dup_fetch;
    end
  end
endmodule

// File: rtl/istr_mem_server_chk.sv
module istr_mem_server_chk #(
  parameter int DATA_W = 64,
  parameter int TYPE_W = 8,
  parameter int CONT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [DATA_W-1:0] req_payload,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [CONT_W-1:0] rsp_cont,
  input logic [DATA_W-1:0] rsp_data,
  input logic [TYPE_W-1:0] rsp_type,
  input logic              err_dup_store,
  input logic              err_dup_fetch
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_REPLY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
  AST_REPLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_cont)
      && $stable(rsp_data) && $stable(rsp_type)); // R10
  AST_FETCH_REPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 2'd0 |=> rsp_valid
      && rsp_cont == $past(req_payload[CONT_W-1:0])); // R2
  AST_STORE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 2'd1 |=> !err_dup_store && !err_dup_fetch); // R3
  AST_ERR_NO_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    err_dup_store || err_dup_fetch |-> !rsp_valid); // R8
  AST_IFETCH_NO_DUP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == 2'd2 |=> !err_dup_store); // R9
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_dup_store, err_dup_fetch})); // R9
endmodule

bind istr_mem_server istr_mem_server_chk #(
  .DATA_W(DATA_W), .TYPE_W(TYPE_W), .CONT_W(CONT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_payload(req_payload), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_cont(rsp_cont), .rsp_data(rsp_data),
  .rsp_type(rsp_type), .err_dup_store(err_dup_store),
  .err_dup_fetch(err_dup_fetch)
);

// File: tb/istr_mem_server_bench.sv
module istr_mem_server_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int DATA_W = 64;
  localparam int TYPE_W = 8;
  localparam int CONT_W = 32;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int TOK_W  = CONT_W + DATA_W + TYPE_W;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [ADDR_W-1:0] req_offset = '0;
  logic [DATA_W-1:0] req_payload = '0;
  logic [TYPE_W-1:0] req_type = '0;
  logic rsp_valid;
  logic rsp_ready = 1;
  logic [CONT_W-1:0] rsp_cont;
  logic [DATA_W-1:0] rsp_data;
  logic [TYPE_W-1:0] rsp_type;
  logic err_dup_store, err_dup_fetch;

  int n_checks = 0;
  int n_fail = 0;
  logic [TOK_W-1:0] expq[$];
  logic [TOK_W-1:0] held_tok;
  logic held = 0;
  logic bp = 0;
  logic last_es, last_ef, last_rv;
  int bp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  istr_mem_server u_istr_mem_server (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_offset(req_offset), .req_payload(req_payload),
    .req_type(req_type), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_cont(rsp_cont), .rsp_data(rsp_data), .rsp_type(rsp_type),
    .err_dup_store(err_dup_store), .err_dup_fetch(err_dup_fetch)
  );

  task automatic check(input string req, input logic [TOK_W-1:0] act,
                       input logic [TOK_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called right after a falling edge; returns right after the falling edge
  // that follows the accepting edge.
  task automatic send(input logic [1:0] op, input int off,
                      input logic [DATA_W-1:0] pay, input logic [TYPE_W-1:0] ty,
                      input logic exp_rep, input logic [TOK_W-1:0] tok);
    while (!req_ready) @(negedge clk);
    if (exp_rep) expq.push_back(tok);
    req_valid = 1; req_op = op; req_offset = ADDR_W'(off);
    req_payload = pay; req_type = ty;
    @(negedge clk);
    req_valid = 0;
    last_es = err_dup_store; last_ef = err_dup_fetch; last_rv = rsp_valid;
  endtask

  function automatic logic [TOK_W-1:0] tk(input logic [CONT_W-1:0] c,
      input logic [DATA_W-1:0] d, input logic [TYPE_W-1:0] t);
    return {c, d, t};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) check("R10 hold", {rsp_valid, rsp_cont, rsp_data, rsp_type},
                      {1'b1, held_tok});
      if (rsp_valid) check("R10 req_ready low", {{(TOK_W-1){1'b0}}, req_ready}, '0);
      held = 0;
      if (rsp_valid && rsp_ready) begin
        if (expq.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2 unexpected reply actual=%h expected=none",
                   {rsp_cont, rsp_data, rsp_type});
        end else begin
          check("R2/R3/R6/R7 reply", {rsp_cont, rsp_data, rsp_type}, expq.pop_front());
        end
      end else if (rsp_valid) begin
        held = 1; held_tok = {rsp_cont, rsp_data, rsp_type};
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      bp_cnt++;
      rsp_ready = bp ? (bp_cnt % 3 == 0) : 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  localparam logic [DATA_W-1:0] VA = 64'h1111_2222_3333_4444;
  localparam logic [DATA_W-1:0] VB = 64'hBEEF_0000_CAFE_0001;
  localparam logic [DATA_W-1:0] VD = 64'hDEAD_DEAD_DEAD_DEAD;
  localparam logic [DATA_W-1:0] VE = 64'h0F0F_0F0F_1234_5678;
  localparam logic [DATA_W-1:0] VF = 64'h7777_0000_0000_0007;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 idle", {{(TOK_W-4){1'b0}}, req_ready, rsp_valid, err_dup_store, err_dup_fetch},
          {{(TOK_W-4){1'b0}}, 4'b1000});
    rst_n = 1;
    @(negedge clk);
    // R1: untouched word reads as zero
    send(2'd0, 5, 64'hAAAA_0000_0000_0C01, 0, 1, tk(32'h0000_0C01, '0, '0));
    // R3, R4: store then fetch, back to back
    send(2'd1, 3, VA, 8'h07, 0, '0);
    send(2'd0, 3, 64'h0000_0000_0000_0C02, 0, 1, tk(32'h0C02, VA, 8'h07));
    // R5: write-once fetch to an empty word parks, no reply
    send(2'd1, 9, VF, 8'h01, 0, '0);
    send(2'd2, 10, 64'h0000_0000_0000_0C03, 0, 0, '0);
    check("R5 no reply", {{(TOK_W-1){1'b0}}, last_rv}, '0);
    // R9: second reader rejected
    send(2'd2, 10, 64'h0000_0000_0000_0C04, 0, 0, '0);
    check("R9 dup fetch", {{(TOK_W-3){1'b0}}, last_ef, last_es, last_rv},
          {{(TOK_W-3){1'b0}}, 3'b100});
    // R6: write-once store releases the original reader
    send(2'd3, 10, VB, 8'h02, 1, tk(32'h0C03, VB, 8'h02));
    // R7: full word replies at once
    send(2'd2, 10, 64'h0000_0000_0000_0C05, 0, 1, tk(32'h0C05, VB, 8'h02));
    // R8: second write-once store rejected, data kept
    send(2'd3, 10, VD, 8'h09, 0, '0);
    check("R8 dup store", {{(TOK_W-3){1'b0}}, last_ef, last_es, last_rv},
          {{(TOK_W-3){1'b0}}, 3'b010});
    send(2'd2, 10, 64'h0000_0000_0000_0C06, 0, 1, tk(32'h0C06, VB, 8'h02));
    // R11: write-once store to empty word
    send(2'd3, 20, VE, 8'h03, 0, '0);
    check("R11 silent", {{(TOK_W-3){1'b0}}, last_ef, last_es, last_rv}, '0);
    send(2'd2, 20, 64'h0000_0000_0000_0C07, 0, 1, tk(32'h0C07, VE, 8'h03));
    // R3: plain store releases a parked reader
    send(2'd2, 30, 64'h0000_0000_0000_0C08, 0, 0, '0);
    send(2'd1, 30, VF, 8'h04, 1, tk(32'h0C08, VF, 8'h04));
    // R10: back-pressure on the reply channel
    bp = 1;
    for (int i = 0; i < 6; i++)
      send(2'd0, 3, 64'(32'h0D00 + i), 0, 1, tk(32'h0D00 + 32'(i), VA, 8'h07));
    send(2'd0, 9, 64'h0000_0000_0000_0C09, 0, 1, tk(32'h0C09, VF, 8'h01));
    repeat (20) @(negedge clk);
    check("R2 all replies drained", TOK_W'(expq.size()), '0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule